// File: doc/BRIEF.md
# Host Interrupt Forwarder with Drain Hold-off

This block takes the interrupt request raised by a network controller and passes it to the host as the active-low PCI INTA line. A request edge is stored as a pending interrupt. The pending interrupt is shown to the host only when the bridge's data FIFO reports empty. This way the host never services an interrupt while data the interrupt refers to is still in flight. Once INTA has been shown, it stays asserted until the host clears it, even if the FIFO later fills again.

The host acknowledges the interrupt by writing the controller's command register. A zero written to the clear bit (bit 8) removes both the pending request and the shown interrupt. A one in that bit, or a write whose byte enables skip that bit, changes nothing. INTA is open-drain: `inta_oe` is the pull-down enable, and `inta_n` is the level seen on the wire.

Top module: `irq_drain_fwd`

## Requirements
- R1: After reset, `inta_n` is 1 and `inta_oe` is 0.
- R2: `irq_req` is a level, and only a 0-to-1 change of it is taken as a new request. When `irq_req` is first sampled high at a clock edge and `fifo_empty` is 1 on the following edge, `inta_n` goes low after that second edge.
- R3: While `fifo_empty` is 0, a pending request is not shown. `inta_n` goes low after the first edge at which `fifo_empty` is sampled 1.
- R4: Once `inta_n` is low, it stays low when `fifo_empty` drops to 0, and stays low until a clearing write.
- R5: A clearing write has `cmd_wr` = 1, `cmd_be[1]` = 1 (the lane holding bit 8) and `cmd_wdata[8]` = 0. It drives `inta_n` high after the edge at which it is sampled.
- R6: A command write with `cmd_wdata[8]` = 1 has no effect on the interrupt state.
- R7: A command write with `cmd_be[1]` = 0 has no effect on the interrupt state, whatever `cmd_wdata` holds.
- R8: A request level that is still high after a clearing write does not raise INTA again. A new 0-to-1 change of `irq_req` is needed.
- R9: When a new request edge and a clearing write fall in the same cycle, INTA is cleared and the new request stays pending. It is shown on the next edge at which the FIFO is empty.
- R10: A clearing write that arrives while a request is pending but not yet shown cancels that request, so no INTA appears when the FIFO drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt request level from the network controller |
| fifo_empty | input | 1 | High when the bridge data FIFO holds no data |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | CMD_W | Write data for the command register |
| cmd_be | input | CMD_W/8 | Byte enables of the command write |
| inta_oe | output | 1 | Pull-down enable for the open-drain INTA line |
| inta_n | output | 1 | INTA level, active low |

## Verification
Two flags hold the whole state: the pending request and the shown interrupt. A fault in either flag shows on `inta_n` within one or two clock edges. A lost pending flag means INTA never falls after the FIFO drains. A shown flag that reacts to FIFO refill lets INTA rise without a clearing write. A wrong clear decode shows on the edge that follows the write: INTA rises on a write of one or on a masked byte lane, or it stays low on a real clear. An edge detector that retriggers on a held level makes INTA return two edges after a clear.

// File: rtl/irq_drain_fwd.sv
module irq_drain_fwd #(
  parameter int CMD_W   = 16,
  parameter int CLR_BIT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_req,
  input  logic               fifo_empty,
  input  logic               cmd_wr,
  input  logic [CMD_W-1:0]   cmd_wdata,
  input  logic [CMD_W/8-1:0] cmd_be,
  output logic               inta_oe,
  output logic               inta_n
);
  localparam int CLR_LANE = CLR_BIT / 8;

  logic irq_prev, pending, shown;

  wire req_edge = irq_req & ~irq_prev;
  wire clr_hit  = cmd_wr & cmd_be[CLR_LANE] & ~cmd_wdata[CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_prev <= 1'b0;
      pending  <= 1'b0;
      shown    <= 1'b0;
    end else begin
      irq_prev <= irq_req;
      if (req_edge)     pending <= 1'b1;
      else if (clr_hit) pending <= 1'b0;
      if (clr_hit)                     shown <= 1'b0;
      else if (pending && fifo_empty)  shown <= 1'b1;
    end
  end

  assign inta_oe = shown;
  assign inta_n  = ~shown;

  // R2
  drain_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending && fifo_empty && !clr_hit |=> !inta_n);
  // R3
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta_n && !fifo_empty |=> inta_n);
  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_n && !clr_hit |=> !inta_n);
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_be[CLR_LANE] && !cmd_wdata[CLR_BIT] |=> inta_n);
  // R6
  write_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_wdata[CLR_BIT] && !inta_n |=> !inta_n);
  // R7
  lane_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !cmd_be[CLR_LANE] && !inta_n |=> !inta_n);
endmodule

// File: tb/tb_irq_drain_fwd.sv
module tb_irq_drain_fwd;
  logic clk = 1'b0;
  logic rst_n;
  logic irq_req, fifo_empty, cmd_wr;
  logic [15:0] cmd_wdata;
  logic [1:0]  cmd_be;
  logic inta_oe, inta_n;

  typedef struct { logic exp_n; string tag; } item_t;
  item_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_drain_fwd dut (.clk(clk), .rst_n(rst_n), .irq_req(irq_req), .fifo_empty(fifo_empty),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_be(cmd_be), .inta_oe(inta_oe), .inta_n(inta_n));

  task automatic cyc(input logic irq, input logic fe, input logic wr, input logic [15:0] d,
                     input logic [1:0] be, input logic exp_n, input string tag);
    item_t it;
    @(negedge clk);
    irq_req = irq; fifo_empty = fe; cmd_wr = wr; cmd_wdata = d; cmd_be = be;
    it.exp_n = exp_n; it.tag = tag;
    sb.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (inta_n !== it.exp_n || inta_oe !== ~it.exp_n) begin
        fails++;
        $display("FAIL %s: inta_n=%b inta_oe=%b expected inta_n=%b", it.tag, inta_n, inta_oe, it.exp_n);
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
    end
  end

  initial begin
    rst_n = 0; irq_req = 0; fifo_empty = 1; cmd_wr = 0; cmd_wdata = 0; cmd_be = 0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (inta_n !== 1'b1 || inta_oe !== 1'b0) begin
      fails++; $display("FAIL R1: inta_n=%b inta_oe=%b expected 1/0", inta_n, inta_oe);
    end
    @(negedge clk); rst_n = 1;
    // R2 basic forwarding
    cyc(1,1,0,16'h0000,2'b00,1,"R2 pending not yet shown");
    cyc(1,1,0,16'h0000,2'b00,0,"R2 shown");
    // R5 clear
    cyc(0,1,1,16'h0000,2'b11,1,"R5 clear");
    // R8 held level
    cyc(1,1,0,16'h0000,2'b00,1,"R8 edge seen");
    cyc(1,1,0,16'h0000,2'b00,0,"R8 shown");
    cyc(1,1,1,16'h0000,2'b11,1,"R8 clear while level high");
    cyc(1,1,0,16'h0000,2'b00,1,"R8 no retrigger 1");
    cyc(1,1,0,16'h0000,2'b00,1,"R8 no retrigger 2");
    cyc(0,1,0,16'h0000,2'b00,1,"R8 level drops");
    // R3 hold-off
    cyc(1,0,0,16'h0000,2'b00,1,"R3 fifo busy 1");
    cyc(0,0,0,16'h0000,2'b00,1,"R3 fifo busy 2");
    cyc(0,0,0,16'h0000,2'b00,1,"R3 fifo busy 3");
    cyc(0,1,0,16'h0000,2'b00,0,"R3 shown after drain");
    // R4 sticky
    cyc(0,0,0,16'h0000,2'b00,0,"R4 refill 1");
    cyc(0,0,0,16'h0000,2'b00,0,"R4 refill 2");
    // R6, R7
    cyc(0,0,1,16'hFFFF,2'b11,0,"R6 write one");
    cyc(0,0,1,16'h0000,2'b01,0,"R7 lane masked");
    cyc(0,1,1,16'h0100,2'b10,0,"R6 write one upper lane");
    cyc(0,1,1,16'hFEFF,2'b10,1,"R5 clear upper lane");
    // R9 simultaneous
    cyc(1,1,0,16'h0000,2'b00,1,"R9 setup edge");
    cyc(1,1,0,16'h0000,2'b00,0,"R9 setup shown");
    cyc(0,1,0,16'h0000,2'b00,0,"R9 level low");
    cyc(1,1,1,16'h0000,2'b11,1,"R9 edge with clear");
    cyc(1,1,0,16'h0000,2'b00,0,"R9 new request shown");
    cyc(0,1,1,16'h0000,2'b11,1,"R9 final clear");
    cyc(0,1,0,16'h0000,2'b00,1,"R9 stays clear");
    // R10 cancel before shown
    cyc(1,0,0,16'h0000,2'b00,1,"R10 pending hidden");
    cyc(0,0,1,16'h0000,2'b11,1,"R10 cancel");
    cyc(0,1,0,16'h0000,2'b00,1,"R10 drain no irq 1");
    cyc(0,1,0,16'h0000,2'b00,1,"R10 drain no irq 2");
    @(negedge clk); cmd_wr = 0;
    repeat (2) @(posedge clk);
    #2;
    done = 1;
    summary();
  end
endmodule